// File: doc/BRIEF.md
# Ethernet receive frame classifier

This block sits beside a MAC receive path and watches each incoming frame one byte at a time. A start strobe opens a frame. Valid bytes are counted. An end marker closes the frame and can carry a dribble-bit flag. While the frame is open, the block keeps a sticky copy of four error inputs: physical-layer error, CRC failure, FIFO overflow and late collision. The first destination-address byte is kept so that multicast frames can be recognised.

One cycle after the end marker, the block presents an 8-bit status word together with a one-cycle accept or discard pulse. The verdict comes from a 5-bit control word. Its bits enable reception, select promiscuous reception, let short frames through, let every multicast frame through, and drop frames that failed the CRC check. Address filtering against the station address is done elsewhere and reaches the block as one match input.

Top module: `rx_frame_screen`

## Requirements
- R1: The status word has this bit layout: bit 7 short frame, bit 6 multicast, bit 5 late collision, bit 4 overlong frame, bit 3 physical-layer error, bit 2 alignment error, bit 1 CRC error, bit 0 FIFO overflow.
- R2: A frame of fewer than 64 counted bytes sets status bit 7. A frame of 64 bytes or more leaves it clear.
- R3: A frame of more than 2048 counted bytes sets status bit 4. A frame of exactly 2048 bytes leaves it clear.
- R4: If the dribble flag is high in the end-marker cycle, status bit 2 is set.
- R5: Status bit 6 copies bit 0 of the first byte of the frame. Later bytes have no effect on it.
- R6: The four error inputs are sticky from the start-strobe cycle up to and including the end-marker cycle. A new start strobe clears them, so pulses on these inputs outside a frame have no effect.
- R7: The control word has this layout: bit 4 drop CRC failures, bit 3 pass all multicast, bit 2 pass short frames, bit 1 promiscuous, bit 0 receive enable. While bit 0 is low at the end marker, the frame is discarded, the status-valid output stays low and the status word reads zero.
- R8: When reception is enabled, a frame qualifies if promiscuous is set, the match input is high at the end marker, or the frame is multicast and pass-all-multicast is set.
- R9: A qualifying frame is still discarded if it is short and pass-short is clear, or if it has a CRC error and drop-CRC is set.
- R10: Status valid, accept and discard are one-cycle pulses that appear in the cycle after the end marker. Accept and discard are never high together. The status word is zero whenever status valid is low.
- R11: An end marker that arrives while no frame is open produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_i | input | 5 | Policy control word (layout in R7) |
| sof_i | input | 1 | Start-of-frame strobe |
| byte_vld_i | input | 1 | Received byte valid |
| byte_i | input | 8 | Received byte |
| eof_i | input | 1 | End-of-frame marker |
| dribble_i | input | 1 | Frame ended off a byte boundary (valid with eof_i) |
| phy_err_i | input | 1 | Physical-layer error |
| crc_bad_i | input | 1 | CRC check failed |
| fifo_ovf_i | input | 1 | Receive FIFO overflow |
| late_col_i | input | 1 | Late collision seen |
| addr_hit_i | input | 1 | Destination address matched (valid with eof_i) |
| stat_vld_o | output | 1 | Status word valid pulse |
| stat_o | output | 8 | Receive status word (layout in R1) |
| accept_o | output | 1 | Frame accepted pulse |
| discard_o | output | 1 | Frame discarded pulse |

## Verification
The assertions assume that the control word is held steady through the end-marker cycle, because each verdict is compared with the value that control had one cycle earlier. The stimulus changes control only between frames and never while a frame is open. The assertions also assume that the end marker is a single-cycle strobe. The driver raises it for exactly one cycle per frame and leaves at least one idle cycle before the next start strobe, so no two verdicts are ever adjacent.

// File: rtl/rxscr_pkg.sv
package rxscr_pkg;

    // status word bit positions
    localparam int ST_SHORT = 7;
    localparam int ST_MCAST = 6;
    localparam int ST_LCOL  = 5;
    localparam int ST_LONG  = 4;
    localparam int ST_PHY   = 3;
    localparam int ST_ALIGN = 2;
    localparam int ST_CRC   = 1;
    localparam int ST_FOVF  = 0;

    // control word bit positions
    localparam int CT_DROP_CRC  = 4;
    localparam int CT_ALL_MCAST = 3;
    localparam int CT_KEEP_SHRT = 2;
    localparam int CT_PROMISC   = 1;
    localparam int CT_RX_ON     = 0;

    localparam int CTRL_W = 5;
    localparam int STAT_W = 8;

    typedef struct packed {
        logic late_col;
        logic phy;
        logic crc;
        logic fifo;
    } err_t;

endpackage

// File: rtl/rxscr_len_track.sv
module rxscr_len_track #(
    parameter int MIN_LEN  = 64,
    parameter int WDOG_LEN = 2048,
    parameter int CNT_W    = 12
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             restart_i,
    input  logic             count_i,
    output logic [CNT_W-1:0] cnt_next_o,
    output logic             first_o,
    output logic             short_o,
    output logic             long_o
);
    localparam int CNT_MAX = WDOG_LEN + 1;

    logic [CNT_W-1:0] base;

    always_comb begin
        base       = restart_i ? '0 : cnt_i;
        first_o    = count_i && (base == '0);
        cnt_next_o = base;
        if (count_i && (base != CNT_W'(CNT_MAX))) begin
            cnt_next_o = base + 1'b1;
        end
        short_o = (cnt_next_o < CNT_W'(MIN_LEN));
        long_o  = (cnt_next_o > CNT_W'(WDOG_LEN));
    end

endmodule

// File: rtl/rxscr_err_sticky.sv
module rxscr_err_sticky
    import rxscr_pkg::*;
(
    input  err_t err_i,
    input  logic restart_i,
    input  logic capture_i,
    input  err_t raw_i,
    output err_t err_next_o
);
    always_comb begin
        err_next_o = restart_i ? '0 : err_i;
        if (capture_i) begin
            err_next_o = err_next_o | raw_i;
        end
    end

endmodule

// File: rtl/rxscr_policy.sv
module rxscr_policy
    import rxscr_pkg::*;
(
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic              short_i,
    input  logic              mcast_i,
    input  logic              crc_i,
    input  logic              hit_i,
    output logic              accept_o
);
    logic wanted;
    logic vetoed;

    always_comb begin
        wanted = ctrl_i[CT_PROMISC] | hit_i | (mcast_i & ctrl_i[CT_ALL_MCAST]);
        vetoed = (short_i & ~ctrl_i[CT_KEEP_SHRT]) | (crc_i & ctrl_i[CT_DROP_CRC]);
        accept_o = ctrl_i[CT_RX_ON] & wanted & ~vetoed;
    end

endmodule

// File: rtl/rx_frame_screen.sv
module rx_frame_screen
    import rxscr_pkg::*;
#(
    parameter int MIN_LEN  = 64,
    parameter int WDOG_LEN = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        ctrl_i,
    input  logic              sof_i,
    input  logic              byte_vld_i,
    input  logic [7:0]        byte_i,
    input  logic              eof_i,
    input  logic              dribble_i,
    input  logic              phy_err_i,
    input  logic              crc_bad_i,
    input  logic              fifo_ovf_i,
    input  logic              late_col_i,
    input  logic              addr_hit_i,
    output logic              stat_vld_o,
    output logic [7:0]        stat_o,
    output logic              accept_o,
    output logic              discard_o
);
    localparam int CNT_W = $clog2(WDOG_LEN + 2);

    typedef struct packed {
        logic              active;
        logic [CNT_W-1:0]  cnt;
        logic              mcast;
        err_t              err;
        logic              out_vld;
        logic [STAT_W-1:0] out_stat;
        logic              out_acc;
        logic              out_dis;
    } state_t;

    state_t st_q, st_d;

    logic             in_frame;
    logic             end_now;
    logic [CNT_W-1:0] cnt_next;
    logic             first_byte;
    logic             is_short;
    logic             is_long;
    err_t             raw_err;
    err_t             err_next;
    logic             mcast_next;
    logic             verdict;
    logic [STAT_W-1:0] word;

    assign in_frame = sof_i | st_q.active;
    assign end_now  = eof_i & in_frame;

    always_comb begin
        raw_err.late_col = late_col_i;
        raw_err.phy      = phy_err_i;
        raw_err.crc      = crc_bad_i;
        raw_err.fifo     = fifo_ovf_i;
    end

    rxscr_len_track #(
        .MIN_LEN  (MIN_LEN),
        .WDOG_LEN (WDOG_LEN),
        .CNT_W    (CNT_W)
    ) u_len (
        .cnt_i      (st_q.cnt),
        .restart_i  (sof_i),
        .count_i    (byte_vld_i & in_frame),
        .cnt_next_o (cnt_next),
        .first_o    (first_byte),
        .short_o    (is_short),
        .long_o     (is_long)
    );

    rxscr_err_sticky u_err (
        .err_i      (st_q.err),
        .restart_i  (sof_i),
        .capture_i  (in_frame),
        .raw_i      (raw_err),
        .err_next_o (err_next)
    );

    always_comb begin
        if (first_byte) begin
            mcast_next = byte_i[0];
        end else if (sof_i) begin
            mcast_next = 1'b0;
        end else begin
            mcast_next = st_q.mcast;
        end
    end

    rxscr_policy u_pol (
        .ctrl_i   (ctrl_i),
        .short_i  (is_short),
        .mcast_i  (mcast_next),
        .crc_i    (err_next.crc),
        .hit_i    (addr_hit_i),
        .accept_o (verdict)
    );

    always_comb begin
        word           = '0;
        word[ST_SHORT] = is_short;
        word[ST_MCAST] = mcast_next;
        word[ST_LCOL]  = err_next.late_col;
        word[ST_LONG]  = is_long;
        word[ST_PHY]   = err_next.phy;
        word[ST_ALIGN] = dribble_i;
        word[ST_CRC]   = err_next.crc;
        word[ST_FOVF]  = err_next.fifo;
    end

    always_comb begin
        st_d          = st_q;
        st_d.active   = in_frame & ~eof_i;
        st_d.cnt      = cnt_next;
        st_d.mcast    = mcast_next;
        st_d.err      = err_next;
        st_d.out_vld  = end_now & ctrl_i[CT_RX_ON];
        st_d.out_stat = (end_now & ctrl_i[CT_RX_ON]) ? word : '0;
        st_d.out_acc  = end_now & verdict;
        st_d.out_dis  = end_now & ~verdict;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_vld_o = st_q.out_vld;
    assign stat_o     = st_q.out_stat;
    assign accept_o   = st_q.out_acc;
    assign discard_o  = st_q.out_dis;

endmodule

// File: rtl/rxscr_chk.sv
module rxscr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] ctrl_i,
    input logic       eof_i,
    input logic       stat_vld_o,
    input logic [7:0] stat_o,
    input logic       accept_o,
    input logic       discard_o
);
    // R10
    one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept_o && discard_o));

    // R10
    after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o || discard_o || stat_vld_o) |-> $past(eof_i));

    // R10
    quiet_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_vld_o |-> (stat_o == 8'h00));

    // R10
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o || discard_o) |=> !(accept_o || discard_o));

    // R7
    rx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (discard_o && !$past(ctrl_i[0])) |-> !stat_vld_o);

    // R7
    accept_needs_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> (stat_vld_o && $past(ctrl_i[0])));

    // R9
    short_veto_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_vld_o && stat_o[7] && !$past(ctrl_i[2])) |-> discard_o);

    // R9
    crc_veto_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_vld_o && stat_o[1] && $past(ctrl_i[4])) |-> discard_o);

    // R8
    promisc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_vld_o && $past(ctrl_i[1]) && !stat_o[7] && !stat_o[1]) |-> accept_o);

endmodule

bind rx_frame_screen rxscr_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_i     (ctrl_i),
    .eof_i      (eof_i),
    .stat_vld_o (stat_vld_o),
    .stat_o     (stat_o),
    .accept_o   (accept_o),
    .discard_o  (discard_o)
);

// File: tb/tb_rx_frame_screen.sv
module tb_rx_frame_screen;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [4:0] ctrl_i;
    logic       sof_i, byte_vld_i, eof_i, dribble_i;
    logic [7:0] byte_i;
    logic       phy_err_i, crc_bad_i, fifo_ovf_i, late_col_i, addr_hit_i;
    logic       stat_vld_o, accept_o, discard_o;
    logic [7:0] stat_o;

    always #10 clk = ~clk;

    rx_frame_screen dut (
        .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl_i), .sof_i(sof_i),
        .byte_vld_i(byte_vld_i), .byte_i(byte_i), .eof_i(eof_i),
        .dribble_i(dribble_i), .phy_err_i(phy_err_i), .crc_bad_i(crc_bad_i),
        .fifo_ovf_i(fifo_ovf_i), .late_col_i(late_col_i), .addr_hit_i(addr_hit_i),
        .stat_vld_o(stat_vld_o), .stat_o(stat_o), .accept_o(accept_o),
        .discard_o(discard_o)
    );

    typedef struct {
        logic       vld;
        logic [7:0] stat;
        logic       acc;
        logic       dis;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks   = 0;
    int   failures = 0;
    bit   done     = 1'b0;

    task automatic idle_inputs();
        sof_i = 0; byte_vld_i = 0; byte_i = 8'h00; eof_i = 0; dribble_i = 0;
        phy_err_i = 0; crc_bad_i = 0; fifo_ovf_i = 0; late_col_i = 0; addr_hit_i = 0;
    endtask

    // errs = {late_col, phy, crc, fifo}, raised on the second byte
    task automatic send_frame(input int len, input logic [7:0] b0, input logic [7:0] b1,
                              input logic [4:0] ctrl, input logic hit,
                              input logic [3:0] errs, input logic crc_end,
                              input logic drib, input string tag);
        exp_t e;
        logic runt, lng, mc, crc;
        runt = (len < 64);
        lng  = (len > 2048);
        mc   = b0[0];
        crc  = errs[1] | crc_end;
        e.vld  = ctrl[0];
        e.stat = ctrl[0] ? {runt, mc, errs[3], lng, errs[2], drib, crc, errs[0]} : 8'h00;
        e.acc  = ctrl[0] & (ctrl[1] | hit | (mc & ctrl[3]))
                 & ~(runt & ~ctrl[2]) & ~(crc & ctrl[4]);
        e.dis  = ~e.acc;
        e.tag  = tag;
        @(negedge clk);
        ctrl_i = ctrl;
        for (int i = 0; i < len; i++) begin
            sof_i = (i == 0);
            byte_vld_i = 1'b1;
            byte_i = (i == 0) ? b0 : (i == 1) ? b1 : 8'hA5;
            {late_col_i, phy_err_i, crc_bad_i, fifo_ovf_i} = (i == 1) ? errs : 4'b0;
            @(negedge clk);
        end
        idle_inputs();
        eof_i = 1'b1;
        dribble_i = drib;
        crc_bad_i = crc_end;
        addr_hit_i = hit;
        exp_q.push_back(e);
        @(negedge clk);
        idle_inputs();
        @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !done && (stat_vld_o || accept_o || discard_o)) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R11 unexpected output vld=%0b stat=%02h acc=%0b dis=%0b expected none",
                         stat_vld_o, stat_o, accept_o, discard_o);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (stat_vld_o !== e.vld || stat_o !== e.stat ||
                    accept_o !== e.acc || discard_o !== e.dis) begin
                    failures++;
                    $display("FAIL %s vld=%0b stat=%02h acc=%0b dis=%0b expected vld=%0b stat=%02h acc=%0b dis=%0b",
                             e.tag, stat_vld_o, stat_o, accept_o, discard_o,
                             e.vld, e.stat, e.acc, e.dis);
                end
            end
        end
    end

    initial begin
        for (int c = 0; c < 200000; c++) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        ctrl_i = 5'b00001;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if ({stat_vld_o, stat_o, accept_o, discard_o} !== 11'b0) begin
            failures++;
            $display("FAIL R10 reset outputs=%03h expected 000",
                     {stat_vld_o, stat_o, accept_o, discard_o});
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R8 unicast match, 64 bytes
        send_frame(64, 8'h00, 8'h00, 5'b00001, 1, 4'b0, 0, 0, "R8");
        // R2 R9 short frame dropped
        send_frame(63, 8'h00, 8'h00, 5'b00001, 1, 4'b0, 0, 0, "R2");
        // R2 short frame kept
        send_frame(63, 8'h00, 8'h00, 5'b00101, 1, 4'b0, 0, 0, "R2");
        // R5 multicast without pass-all
        send_frame(70, 8'h01, 8'h00, 5'b00001, 0, 4'b0, 0, 0, "R5");
        // R8 multicast with pass-all
        send_frame(70, 8'h01, 8'h00, 5'b01001, 0, 4'b0, 0, 0, "R8");
        // R5 bit 0 of second byte has no effect
        send_frame(70, 8'h02, 8'h01, 5'b01001, 0, 4'b0, 0, 0, "R5");
        // R8 promiscuous
        send_frame(70, 8'h00, 8'h00, 5'b00011, 0, 4'b0, 0, 0, "R8");
        // R6 crc failure mid-frame, kept
        send_frame(70, 8'h00, 8'h00, 5'b00001, 1, 4'b0010, 0, 0, "R6");
        // R9 crc failure at end, dropped
        send_frame(70, 8'h00, 8'h00, 5'b10001, 1, 4'b0000, 1, 0, "R9");
        // R1 R6 late collision, phy and fifo errors
        send_frame(80, 8'h00, 8'h00, 5'b00001, 1, 4'b1101, 0, 0, "R1");
        // R6 next frame starts clean
        send_frame(80, 8'h00, 8'h00, 5'b00001, 1, 4'b0, 0, 0, "R6");
        // R4 dribble
        send_frame(66, 8'h00, 8'h00, 5'b00001, 1, 4'b0, 0, 1, "R4");
        // R3 boundary: exactly 2048, then 2049
        send_frame(2048, 8'h00, 8'h00, 5'b00001, 1, 4'b0, 0, 0, "R3");
        send_frame(2049, 8'h00, 8'h00, 5'b00001, 1, 4'b0, 0, 0, "R3");
        // R7 receiver off
        send_frame(70, 8'h01, 8'h00, 5'b01010, 1, 4'b1111, 0, 1, "R7");

        // R6 errors while idle are ignored
        phy_err_i = 1; late_col_i = 1; fifo_ovf_i = 1; crc_bad_i = 1;
        @(negedge clk);
        idle_inputs();
        send_frame(64, 8'h00, 8'h00, 5'b00001, 1, 4'b0, 0, 0, "R6");

        // R11 stray end marker
        eof_i = 1'b1;
        @(negedge clk);
        eof_i = 1'b0;
        @(negedge clk);
        checks++;
        if ({stat_vld_o, accept_o, discard_o} !== 3'b0) begin
            failures++;
            $display("FAIL R11 stray eof outputs=%03b expected 000",
                     {stat_vld_o, accept_o, discard_o});
        end

        repeat (4) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R10 missing results=%0d expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule